// File: doc/BRIEF.md
# Smart card power sequencer

This block brings a contact smart card up and down in a fixed, timed order. It runs from a slow timing clock of 1.5 MHz. A host requests a session with an active-low power command. The block then enables the card supply and waits for the supply to settle. It checks that the supply is valid, enables I/O reception and starts the card clock. After that, the card reset output tracks the host's reset request. When the host withdraws the command, or when a fault or card removal occurs, the block lowers the card signals one at a time, with fixed spacing between them, and then switches the supply off.

The clock can start in one of two ways. If the reset request is low when activation begins, I/O reception and the clock follow the supply check after fixed delays. If the reset request is high, I/O reception is enabled at the supply check and the clock waits for the reset request to fall. An active-low interrupt line tells the host about card presence while no session is running, and about faults while a session is running. A power-on lockout refuses activation for a fixed time after reset.

The regulator, the fault comparators and the oscillator are outside the block. They reach it as asynchronous digital flags, and each flag passes through a two-flop synchronizer.

Top module: `card_power_seq`

## Requirements
- R1: For LOCK_TICKS cycles after reset is released (15000 by default, which is 10 ms), a falling edge of `pwr_cmd_n` does not activate the card.
- R2: Activation starts only on a falling edge of `pwr_cmd_n`, and only while `card_present` is 1 and `supply_fault` is 0. Each input reaches a registered output 3 clock cycles after it changes: two synchronizer stages, then the output register. `card_vcc_en` rises at that point.
- R3: `vcc_good` is sampled once, RAMP_TICKS cycles (765 by default) after `card_vcc_en` rises. If it is 0 at that sample, `card_vcc_en` falls and `host_irq_n` goes low in the same cycle.
- R4: If `rst_req` was 0 when activation started, `card_io_en` rises IO_TICKS (3) cycles after the supply check, and `card_clk_en` rises CLK_TICKS (1) cycle after that.
- R5: If `rst_req` was 1 when activation started, `card_io_en` rises at the supply check and `card_clk_en` stays 0 until `rst_req` falls. The clock then starts 3 cycles after that fall.
- R6: `card_rst` stays 0 until the card clock runs. From then on it copies `rst_req`, 3 cycles behind.
- R7: Deactivation lowers the signals in a fixed order, each step counted from the previous one. `card_rst` goes low after 1 cycle, `card_clk_en` after a further 12, `card_io_en` after a further 1, and `card_vcc_en` after a further 1.
- R8: A session is deactivated by `pwr_cmd_n` returning high, or by `over_current`, `supply_fault`, loss of `vcc_good` after the check, or `card_present` falling. Every cause except the command drives `host_irq_n` low in the same cycle that deactivation starts.
- R9: All outputs are 0 during reset. Outside a session, `host_irq_n` equals `card_present`, and fault flags have no effect on it.
- R10: `card_vsel_5v` takes the value of `volt_sel` when activation starts. Changes to `volt_sel` during the session are ignored.
- R11: A falling edge of `pwr_cmd_n` that arrives during deactivation is held. A new activation starts one cycle after the supply has been switched off.
- R12: After a fault, `host_irq_n` stays low until `pwr_cmd_n` has returned high, even if the fault has gone away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, 1.5 MHz |
| rst_n | input | 1 | Active-low reset; it is released when the logic supply becomes valid |
| pwr_cmd_n | input | 1 | Active-low power command from the host (asynchronous) |
| rst_req | input | 1 | Host card reset request (asynchronous) |
| volt_sel | input | 1 | Supply level request: 1 selects 5 V, 0 selects 3 V (asynchronous) |
| card_present | input | 1 | Card presence switch, 1 when a card is present (asynchronous) |
| supply_fault | input | 1 | Logic supply fault flag (asynchronous) |
| over_current | input | 1 | Card over-current flag (asynchronous) |
| vcc_good | input | 1 | Card supply valid flag (asynchronous) |
| card_vcc_en | output | 1 | Card supply enable |
| card_vsel_5v | output | 1 | Supply level latched at activation |
| card_io_en | output | 1 | I/O reception enable |
| card_clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset |
| host_irq_n | output | 1 | Active-low interrupt to the host |

## Verification
Activation is tried three ways, and each one exercises a different exit from the supply check. With the reset request low, the delay-driven clock start is used. With the reset request high, the clock waits for the reset request to fall. With the supply flag held invalid, the check fails and the block aborts straight to off. Deactivation is started by the command, by over-current and by extraction. This separates the quiet shutdown from one that raises the interrupt. It also shows whether the interrupt stays latched until the command returns high. A command edge is dropped inside the shutdown window to show that the restart is deferred rather than lost. Commands are also issued during lockout, with no card and with a supply fault, to show that each one is refused.

// File: rtl/scs_pkg.sv
package scs_pkg;

    // Sequencer states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RAMP,
        ST_IO_WAIT,
        ST_CLK_WAIT,
        ST_RST_WAIT,
        ST_ACTIVE,
        ST_DN_RST,
        ST_DN_CLK,
        ST_DN_IO,
        ST_DN_VCC
    } seq_state_e;

    // Bit positions of the synchronized input vector
    localparam int IN_CMD   = 0;
    localparam int IN_RREQ  = 1;
    localparam int IN_VSEL  = 2;
    localparam int IN_PRES  = 3;
    localparam int IN_SUPF  = 4;
    localparam int IN_OVC   = 5;
    localparam int IN_VOK   = 6;
    localparam int IN_W     = 7;

endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
    parameter int             W    = 1,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= INIT;
            s2_q <= INIT;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/scs_lockout.sv
module scs_lockout #(
    parameter int LOCK_TICKS = 15000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CW = $clog2(LOCK_TICKS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(LOCK_TICKS);
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);
endmodule

// File: rtl/scs_seq_core.sv
module scs_seq_core
    import scs_pkg::*;
#(
    parameter int RAMP_TICKS   = 765,
    parameter int IO_TICKS     = 3,
    parameter int CLK_TICKS    = 1,
    parameter int DN_RST_TICKS = 1,
    parameter int DN_CLK_TICKS = 12,
    parameter int DN_IO_TICKS  = 1,
    parameter int DN_VCC_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_n_s,
    input  logic rreq_s,
    input  logic vsel_s,
    input  logic pres_s,
    input  logic supf_s,
    input  logic ovc_s,
    input  logic vok_s,
    input  logic lock_ready,
    output logic vcc_en,
    output logic vsel_out,
    output logic io_en,
    output logic clk_en,
    output logic card_rst,
    output logic irq_n
);
    localparam int TICK_SUM = RAMP_TICKS + IO_TICKS + CLK_TICKS + DN_RST_TICKS
                            + DN_CLK_TICKS + DN_IO_TICKS + DN_VCC_TICKS;
    localparam int CNT_W    = $clog2(TICK_SUM + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             vcc_en;
        logic             vsel;
        logic             io_en;
        logic             clk_en;
        logic             crst;
        logic             irq_n;
        logic             fault;
        logic             pend;
        logic             rst_hi;
        logic             cmd_prev;
    } core_t;

    core_t d, q;

    logic cmd_fell, last, in_run, post_chk, hw_fault;

    always_comb begin
        d        = q;
        cmd_fell = q.cmd_prev & ~cmd_n_s;
        last     = (q.cnt == '0);
        in_run   = (q.st == ST_RAMP) || (q.st == ST_IO_WAIT) || (q.st == ST_CLK_WAIT)
                || (q.st == ST_RST_WAIT) || (q.st == ST_ACTIVE);
        post_chk = in_run && (q.st != ST_RAMP);
        hw_fault = ovc_s | supf_s | ~pres_s | (post_chk & ~vok_s);

        d.cmd_prev = cmd_n_s;
        if (!last) d.cnt = q.cnt - 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                d.pend = 1'b0;
                if (cmd_n_s) d.fault = 1'b0;
                if (!cmd_n_s && (cmd_fell || q.pend) && pres_s && !supf_s && lock_ready) begin
                    d.st     = ST_RAMP;
                    d.cnt    = CNT_W'(RAMP_TICKS - 1);
                    d.vcc_en = 1'b1;
                    d.vsel   = vsel_s;
                    d.rst_hi = rreq_s;
                    d.fault  = 1'b0;
                end
            end
            ST_RAMP: begin
                if (last) begin
                    if (!vok_s) begin
                        d.vcc_en = 1'b0;
                        d.fault  = 1'b1;
                        d.st     = ST_IDLE;
                    end else if (q.rst_hi) begin
                        d.io_en = 1'b1;
                        d.st    = ST_RST_WAIT;
                    end else begin
                        d.st  = ST_IO_WAIT;
                        d.cnt = CNT_W'(IO_TICKS - 1);
                    end
                end
            end
            ST_IO_WAIT: begin
                if (last) begin
                    d.io_en = 1'b1;
                    d.st    = ST_CLK_WAIT;
                    d.cnt   = CNT_W'(CLK_TICKS - 1);
                end
            end
            ST_CLK_WAIT: begin
                if (last) begin
                    d.clk_en = 1'b1;
                    d.crst   = rreq_s;
                    d.st     = ST_ACTIVE;
                end
            end
            ST_RST_WAIT: begin
                if (!rreq_s) begin
                    d.clk_en = 1'b1;
                    d.crst   = 1'b0;
                    d.st     = ST_ACTIVE;
                end
            end
            ST_ACTIVE: d.crst = rreq_s;
            ST_DN_RST: begin
                if (cmd_fell) d.pend = 1'b1;
                if (last) begin
                    d.crst = 1'b0;
                    d.st   = ST_DN_CLK;
                    d.cnt  = CNT_W'(DN_CLK_TICKS - 1);
                end
            end
            ST_DN_CLK: begin
                if (cmd_fell) d.pend = 1'b1;
                if (last) begin
                    d.clk_en = 1'b0;
                    d.st     = ST_DN_IO;
                    d.cnt    = CNT_W'(DN_IO_TICKS - 1);
                end
            end
            ST_DN_IO: begin
                if (cmd_fell) d.pend = 1'b1;
                if (last) begin
                    d.io_en = 1'b0;
                    d.st    = ST_DN_VCC;
                    d.cnt   = CNT_W'(DN_VCC_TICKS - 1);
                end
            end
            ST_DN_VCC: begin
                if (cmd_fell) d.pend = 1'b1;
                if (last) begin
                    d.vcc_en = 1'b0;
                    d.st     = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // Any stop request in a running session overrides the step above
        if (in_run && (cmd_n_s || hw_fault)) begin
            d        = q;
            d.cmd_prev = cmd_n_s;
            d.st     = ST_DN_RST;
            d.cnt    = CNT_W'(DN_RST_TICKS - 1);
            d.fault  = hw_fault;
            d.pend   = 1'b0;
        end

        d.irq_n = d.fault ? 1'b0 : ((d.st == ST_IDLE) ? pres_s : 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.cmd_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign vcc_en   = q.vcc_en;
    assign vsel_out = q.vsel;
    assign io_en    = q.io_en;
    assign clk_en   = q.clk_en;
    assign card_rst = q.crst;
    assign irq_n    = q.irq_n;

    // R6
    rst_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.crst |-> q.clk_en);
    // R4
    clk_needs_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.clk_en |-> q.io_en);
    // R5
    io_needs_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.io_en |-> q.vcc_en);
    // R7
    vcc_off_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.vcc_en) |-> !q.io_en && !q.clk_en);
    // R7
    clk_off_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.clk_en) |-> !q.crst);
    // R10
    vsel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.vcc_en && $past(q.vcc_en)) |-> $stable(q.vsel));
endmodule

// File: rtl/card_power_seq.sv
module card_power_seq
    import scs_pkg::*;
#(
    parameter int LOCK_TICKS   = 15000,
    parameter int RAMP_TICKS   = 765,
    parameter int IO_TICKS     = 3,
    parameter int CLK_TICKS    = 1,
    parameter int DN_RST_TICKS = 1,
    parameter int DN_CLK_TICKS = 12,
    parameter int DN_IO_TICKS  = 1,
    parameter int DN_VCC_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_cmd_n,
    input  logic rst_req,
    input  logic volt_sel,
    input  logic card_present,
    input  logic supply_fault,
    input  logic over_current,
    input  logic vcc_good,
    output logic card_vcc_en,
    output logic card_vsel_5v,
    output logic card_io_en,
    output logic card_clk_en,
    output logic card_rst,
    output logic host_irq_n
);
    localparam logic [IN_W-1:0] SYNC_INIT = IN_W'(1) << IN_CMD;

    logic [IN_W-1:0] raw_in, syn_in;
    logic            lock_ready;

    assign raw_in = {vcc_good, over_current, supply_fault, card_present,
                     volt_sel, rst_req, pwr_cmd_n};

    scs_sync #(.W(IN_W), .INIT(SYNC_INIT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    scs_lockout #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (lock_ready)
    );

    scs_seq_core #(
        .RAMP_TICKS   (RAMP_TICKS),
        .IO_TICKS     (IO_TICKS),
        .CLK_TICKS    (CLK_TICKS),
        .DN_RST_TICKS (DN_RST_TICKS),
        .DN_CLK_TICKS (DN_CLK_TICKS),
        .DN_IO_TICKS  (DN_IO_TICKS),
        .DN_VCC_TICKS (DN_VCC_TICKS)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_n_s    (syn_in[IN_CMD]),
        .rreq_s     (syn_in[IN_RREQ]),
        .vsel_s     (syn_in[IN_VSEL]),
        .pres_s     (syn_in[IN_PRES]),
        .supf_s     (syn_in[IN_SUPF]),
        .ovc_s      (syn_in[IN_OVC]),
        .vok_s      (syn_in[IN_VOK]),
        .lock_ready (lock_ready),
        .vcc_en     (card_vcc_en),
        .vsel_out   (card_vsel_5v),
        .io_en      (card_io_en),
        .clk_en     (card_clk_en),
        .card_rst   (card_rst),
        .irq_n      (host_irq_n)
    );

    // R1
    lockout_no_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_ready |-> !card_vcc_en);
endmodule

// File: tb/card_power_seq_tb.sv
module card_power_seq_tb;
    localparam int LOCK = 15000;
    localparam int S    = 765;
    localparam int IOT  = 3;
    localparam int CKT  = 1;
    localparam int DR   = 1;
    localparam int DC   = 12;
    localparam int DI   = 1;
    localparam int DV   = 1;
    localparam int B_IRQ = 5, B_VCC = 4, B_SEL = 3, B_IO = 2, B_CLK = 1, B_RST = 0;

    typedef struct {
        int         cyc;
        logic [5:0] vec;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_cmd_n = 1'b1, rst_req = 1'b0, volt_sel = 1'b1, card_present = 1'b1;
    logic supply_fault = 1'b0, over_current = 1'b0, vcc_good = 1'b1;
    logic card_vcc_en, card_vsel_5v, card_io_en, card_clk_en, card_rst, host_irq_n;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    string phase = "R9";
    logic [5:0] mv = '0;
    logic [5:0] prev_v = '0;
    logic [5:0] outv;
    exp_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    card_power_seq u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_cmd_n(pwr_cmd_n), .rst_req(rst_req),
        .volt_sel(volt_sel), .card_present(card_present), .supply_fault(supply_fault),
        .over_current(over_current), .vcc_good(vcc_good),
        .card_vcc_en(card_vcc_en), .card_vsel_5v(card_vsel_5v), .card_io_en(card_io_en),
        .card_clk_en(card_clk_en), .card_rst(card_rst), .host_irq_n(host_irq_n)
    );

    assign outv = {host_irq_n, card_vcc_en, card_vsel_5v, card_io_en, card_clk_en, card_rst};

    // Monitor: every output change must match the next expected item
    always @(negedge clk) begin
        exp_t e;
        if (mon_on && outv !== prev_v) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL %s: unexpected change at cycle %0d, actual %b expected %b",
                         phase, cyc, outv, prev_v);
            end else begin
                e = exp_q.pop_front();
                if (e.cyc != cyc || e.vec !== outv) begin
                    n_err++;
                    $display("FAIL %s: actual %b at cycle %0d, expected %b at cycle %0d",
                             e.req, outv, cyc, e.vec, e.cyc);
                end
            end
        end
        prev_v = outv;
    end

    task automatic expect_at(int c, int b, logic v, string req);
        exp_t e;
        if (mv[b] === v) return;
        mv[b] = v;
        if (exp_q.size() > 0 && exp_q[exp_q.size()-1].cyc == c)
            exp_q[exp_q.size()-1].vec = mv;
        else begin
            e.cyc = c; e.vec = mv; e.req = req;
            exp_q.push_back(e);
        end
    endtask

    task automatic wait_drain(int maxc, string req);
        int w = 0;
        while (exp_q.size() != 0 && w < maxc) begin
            @(negedge clk);
            w++;
        end
        if (exp_q.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL %s: expected %b at cycle %0d never seen, actual %b",
                     exp_q[0].req, exp_q[0].vec, exp_q[0].cyc, outv);
            exp_q.delete();
        end
    endtask

    task automatic check_now(string req);
        @(negedge clk);
        n_chk++;
        if (outv !== mv) begin
            n_err++;
            $display("FAIL %s: outputs actual %b expected %b at cycle %0d", req, outv, mv, cyc);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic activate(bit path_b, string req);
        int e;
        @(negedge clk);
        phase = req;
        pwr_cmd_n = 1'b0;
        e = cyc + 3;
        expect_at(e, B_VCC, 1'b1, "R2");
        expect_at(e, B_SEL, volt_sel, "R10");
        if (!path_b) begin
            expect_at(e + S + IOT, B_IO, 1'b1, req);
            expect_at(e + S + IOT + CKT, B_CLK, 1'b1, req);
        end else begin
            expect_at(e + S, B_IO, 1'b1, req);
        end
        wait_drain(S + 40, req);
    endtask

    task automatic deact_expect(int f, bit flt, string req);
        if (flt) expect_at(f, B_IRQ, 1'b0, "R8");
        expect_at(f + DR, B_RST, 1'b0, req);
        expect_at(f + DR + DC, B_CLK, 1'b0, req);
        expect_at(f + DR + DC + DI, B_IO, 1'b0, req);
        expect_at(f + DR + DC + DI + DV, B_VCC, 1'b0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int rel, f;
        // R9: reset state
        tick(5);
        n_chk++;
        if (outv !== 6'b0) begin
            n_err++;
            $display("FAIL R9: reset outputs actual %b expected %b", outv, 6'b0);
        end
        prev_v = outv;
        mon_on = 1'b1;
        rel = cyc;
        rst_n = 1'b1;
        expect_at(rel + 3, B_IRQ, 1'b1, "R9");
        wait_drain(10, "R9");

        // R1: command edge inside the lockout window is refused
        while (cyc < rel + 100) @(negedge clk);
        phase = "R1";
        pwr_cmd_n = 1'b0;
        tick(200);
        check_now("R1");
        pwr_cmd_n = 1'b1;
        while (cyc < rel + LOCK + 10) @(negedge clk);

        // R2: no card -> refused; presence reflected on irq (R9)
        phase = "R9";
        card_present = 1'b0;
        expect_at(cyc + 3, B_IRQ, 1'b0, "R9");
        wait_drain(10, "R9");
        @(negedge clk); phase = "R2"; pwr_cmd_n = 1'b0;
        tick(30);
        check_now("R2");
        pwr_cmd_n = 1'b1;
        tick(5);
        card_present = 1'b1;
        expect_at(cyc + 3, B_IRQ, 1'b1, "R9");
        wait_drain(10, "R9");

        // R2: supply fault -> refused; fault outside session no irq effect (R9)
        @(negedge clk); phase = "R9"; supply_fault = 1'b1;
        tick(10);
        check_now("R9");
        @(negedge clk); phase = "R2"; pwr_cmd_n = 1'b0;
        tick(30);
        check_now("R2");
        pwr_cmd_n = 1'b1; supply_fault = 1'b0;
        tick(5);

        // R4 path, 5 V, then reset follow (R6), vsel ignored (R10), command stop (R7)
        activate(1'b0, "R4");
        @(negedge clk); phase = "R6"; rst_req = 1'b1;
        expect_at(cyc + 3, B_RST, 1'b1, "R6");
        wait_drain(10, "R6");
        @(negedge clk); phase = "R10"; volt_sel = 1'b0;
        tick(20);
        check_now("R10");
        @(negedge clk); phase = "R7"; pwr_cmd_n = 1'b1;
        f = cyc + 3;
        deact_expect(f, 1'b0, "R7");
        wait_drain(60, "R7");

        // R5 path, 3 V latched, reset held until clock, over-current stop (R8, R12)
        @(negedge clk); rst_req = 1'b1;
        activate(1'b1, "R5");
        check_now("R6");
        @(negedge clk); phase = "R5"; rst_req = 1'b0;
        expect_at(cyc + 3, B_CLK, 1'b1, "R5");
        wait_drain(10, "R5");
        @(negedge clk); phase = "R6"; rst_req = 1'b1;
        expect_at(cyc + 3, B_RST, 1'b1, "R6");
        wait_drain(10, "R6");
        @(negedge clk); phase = "R8"; over_current = 1'b1;
        f = cyc + 3;
        deact_expect(f, 1'b1, "R8");
        wait_drain(60, "R8");
        @(negedge clk); over_current = 1'b0;
        tick(20);
        check_now("R12");
        @(negedge clk); phase = "R12"; pwr_cmd_n = 1'b1;
        expect_at(cyc + 3, B_IRQ, 1'b1, "R12");
        wait_drain(10, "R12");
        @(negedge clk); rst_req = 1'b0;

        // R3: supply never valid at the check
        @(negedge clk); phase = "R3"; vcc_good = 1'b0; volt_sel = 1'b1;
        @(negedge clk); pwr_cmd_n = 1'b0;
        f = cyc + 3;
        expect_at(f, B_VCC, 1'b1, "R2");
        expect_at(f, B_SEL, 1'b1, "R10");
        expect_at(f + S, B_VCC, 1'b0, "R3");
        expect_at(f + S, B_IRQ, 1'b0, "R3");
        wait_drain(S + 40, "R3");
        tick(10);
        check_now("R3");
        @(negedge clk); phase = "R12"; pwr_cmd_n = 1'b1; vcc_good = 1'b1;
        expect_at(cyc + 3, B_IRQ, 1'b1, "R12");
        wait_drain(10, "R12");

        // R8: extraction during session
        activate(1'b0, "R4");
        @(negedge clk); phase = "R8"; card_present = 1'b0;
        f = cyc + 3;
        deact_expect(f, 1'b1, "R8");
        wait_drain(60, "R8");
        @(negedge clk); card_present = 1'b1;
        tick(10);
        check_now("R12");
        @(negedge clk); phase = "R12"; pwr_cmd_n = 1'b1;
        expect_at(cyc + 3, B_IRQ, 1'b1, "R12");
        wait_drain(10, "R12");

        // R11: new command edge during deactivation is deferred
        activate(1'b0, "R4");
        @(negedge clk); phase = "R11"; pwr_cmd_n = 1'b1;
        f = cyc + 3;
        tick(6);
        pwr_cmd_n = 1'b0;
        deact_expect(f, 1'b0, "R7");
        expect_at(f + DR + DC + DI + DV + 1, B_VCC, 1'b1, "R11");
        expect_at(f + DR + DC + DI + DV + 1 + S + IOT, B_IO, 1'b1, "R11");
        expect_at(f + DR + DC + DI + DV + 1 + S + IOT + CKT, B_CLK, 1'b1, "R11");
        wait_drain(S + 80, "R11");
        @(negedge clk); phase = "R7"; pwr_cmd_n = 1'b1;
        f = cyc + 3;
        deact_expect(f, 1'b0, "R7");
        wait_drain(60, "R7");

        // R9: faults outside session leave irq alone
        @(negedge clk); phase = "R9"; supply_fault = 1'b1; over_current = 1'b1;
        tick(10);
        check_now("R9");
        @(negedge clk); supply_fault = 1'b0; over_current = 1'b0;
        tick(10);
        check_now("R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule